// File: doc/BRIEF.md
# Whitening Bit-Stream Frame Builder

This block turns blocks of payload bytes into transmit frames and sends them out one bit per handshake, for a bit-serial modulator that follows it. A frame is opened by a fixed 32-bit alignment word. A 16-bit byte count follows. Then comes the payload, scrambled by a short pseudo-random sequence so that the line bits look random. A 16-bit CRC of the unscrambled payload closes the frame.

A producer first offers the block's byte count on a length channel. It then offers the payload bytes on a separate byte channel, each byte under a valid/ready handshake. The bit output is also valid/ready. Backpressure is followed bit by bit and nothing is dropped. The output valid drops only while the builder is waiting for a payload byte. A byte can be taken on the same cycle as the final bit of the previous field. The next frame's length can be taken on the final CRC bit. With a producer that is always ready, the line therefore carries no idle cycles, either within a frame or between frames.

Top module: `fb_frame_builder`

## Requirements
- R1: On the cycle after a length is accepted, the output is valid and starts the alignment word (parameter default 0xA5F03C96). All 32 bits of the word are sent most significant bit first.
- R2: The 16-bit payload byte count follows the alignment word, most significant bit first.
- R3: Each payload byte is sent most significant bit first. Each bit is XORed with bit 6 of a 7-bit scrambler state, which then steps to {state[5:0], state[6]^state[3]}, the sequence of x^7+x^4+1. Only payload bits are scrambled.
- R4: The scrambler state is set to all ones at the start of every frame, so equal payloads in consecutive frames give equal line bits.
- R5: The final 16 bits of a frame are a CRC of the unscrambled payload bytes, sent most significant bit first. The CRC uses polynomial 0x1021 and is shifted most significant bit first, with start value 0xFFFF, no reflection and no final XOR. The bytes "123456789" give 0x29B1.
- R6: A zero length gives a frame of the alignment word, a count of zero and a CRC of 0xFFFF.
- R7: While the output is valid and not accepted, the output stays valid and the bit does not change. No bit is lost or repeated.
- R8: Inside a frame, the output valid is low only while the builder is waiting for a payload byte, and it holds the byte ready high during that wait.
- R9: When payload bytes and the next length are always offered and the output is always ready, the bit stream has no gap, within frames or between them.
- R10: During and after reset, with no input offered, the output valid and the byte ready are low and the length ready is high.
- R11: A new length is accepted only between frames, or on the cycle in which the last CRC bit of the current frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_len_valid | input | 1 | Byte count of the next frame is offered |
| s_len_ready | output | 1 | Builder accepts a byte count |
| s_len | input | 16 | Payload byte count of the next frame |
| s_byte_valid | input | 1 | Payload byte is offered |
| s_byte_ready | output | 1 | Builder accepts a payload byte |
| s_byte | input | 8 | Payload byte |
| m_bit_valid | output | 1 | Line bit is valid |
| m_bit_ready | input | 1 | Downstream accepts the line bit |
| m_bit | output | 1 | Line bit |

## Verification
Payloads of all zeros show the bare scrambler sequence on the line. Payloads of all ones show its complement. Counting and mixed-value bytes separate the bit order within a byte from the byte order. The test set covers byte counts of zero to nine and one longer block. The runs are queued back to back, so the reseed between frames and the hand-over from the last CRC bit to the next frame are both tested. The same frames are sent again with periodic output stalls and gaps in the byte supply. This separates holding a stalled bit from losing it, and shows that valid falls only during a wait for a byte. The standard check string "123456789" fixes the CRC convention.

// File: rtl/fb_pkg.sv
`timescale 1ns/1ps
package fb_pkg;

    localparam int BYTE_W   = 8;
    localparam int SYNC_W   = 32;
    localparam int LEN_W    = 16;
    localparam int CRC_W    = 16;
    localparam int LFSR_W   = 7;
    localparam int LFSR_TAP = 3;
    localparam int SHIFT_W  = SYNC_W;
    localparam int CNT_W    = $clog2(SHIFT_W);

    localparam logic [CRC_W-1:0]  CRC_POLY  = 16'h1021;
    localparam logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_LEN,
        ST_WAIT,
        ST_PAY,
        ST_CRC
    } fb_state_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] word;
        logic [CNT_W-1:0]   nbits_m1;
    } fb_load_t;

    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  c,
        input logic [BYTE_W-1:0] d
    );
        logic [CRC_W-1:0] r;
        r = c ^ {d, {(CRC_W-BYTE_W){1'b0}}};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP]};
    endfunction

endpackage

// File: rtl/fb_whitener.sv
`timescale 1ns/1ps
module fb_whitener
    import fb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seed_i,
    input  logic step_i,
    output logic mask_o
);

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LFSR_SEED;
        end else if (seed_i) begin
            state_q <= LFSR_SEED;
        end else if (step_i) begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign mask_o = state_q[LFSR_W-1];

    // R4: a reseed leaves the scrambler in the all-ones state
    p_seed_all_ones_r4: assert property (@(posedge clk) disable iff (rst)
        seed_i |=> (state_q == LFSR_SEED));

    // R3: a maximal-length scrambler never reaches the all-zero state
    p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (state_q != '0));

endmodule

// File: rtl/fb_crc16.sv
`timescale 1ns/1ps
module fb_crc16
    import fb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              upd_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_INIT;
        end else if (init_i) begin
            crc_q <= CRC_INIT;
        end else if (upd_i) begin
            crc_q <= crc_step_byte(crc_q, byte_i);
        end
    end

    assign crc_o = crc_q;

    // R6: a fresh frame starts from the defined start value
    p_init_value_r6: assert property (@(posedge clk) disable iff (rst)
        (init_i && !upd_i) |=> (crc_o == CRC_INIT));

    // R5: the remainder only moves when a byte is folded in
    p_crc_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!init_i && !upd_i) |=> $stable(crc_o));

endmodule

// File: rtl/fb_field_shifter.sv
`timescale 1ns/1ps
module fb_field_shifter
    import fb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  fb_load_t load_data_i,
    input  logic     shift_i,
    output logic     bit_o,
    output logic     last_o
);

    logic [SHIFT_W-1:0] word_q;
    logic [CNT_W-1:0]   left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            word_q <= load_data_i.word;
            left_q <= load_data_i.nbits_m1;
        end else if (shift_i) begin
            word_q <= word_q << 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_o  = word_q[SHIFT_W-1];
    assign last_o = (left_q == '0);

    // R7: a field is never shifted past its final bit
    p_no_underrun_r7: assert property (@(posedge clk) disable iff (rst)
        !(shift_i && !load_i && last_o));

endmodule

// File: rtl/fb_frame_builder.sv
`timescale 1ns/1ps
module fb_frame_builder
    import fb_pkg::*;
#(
    parameter logic [SYNC_W-1:0] SYNC_WORD = 32'hA5F0_3C96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_len_valid,
    output logic              s_len_ready,
    input  logic [LEN_W-1:0]  s_len,
    input  logic              s_byte_valid,
    output logic              s_byte_ready,
    input  logic [BYTE_W-1:0] s_byte,
    output logic              m_bit_valid,
    input  logic              m_bit_ready,
    output logic              m_bit
);

    localparam int LEN_PAD  = SHIFT_W - LEN_W;
    localparam int BYTE_PAD = SHIFT_W - BYTE_W;
    localparam int CRC_PAD  = SHIFT_W - CRC_W;

    fb_state_e        st_q, st_d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rem_q;

    logic     sh_bit, sh_last, sh_load, sh_shift;
    fb_load_t sh_data;
    logic     wh_mask;
    logic [CRC_W-1:0] crc_val;

    logic bit_fire, field_done, len_take, byte_take;
    logic want_byte, pay_done;

    assign m_bit_valid = (st_q == ST_SYNC) || (st_q == ST_LEN) ||
                         (st_q == ST_PAY)  || (st_q == ST_CRC);
    assign bit_fire    = m_bit_valid && m_bit_ready;
    assign field_done  = bit_fire && sh_last;
    assign m_bit       = sh_bit ^ ((st_q == ST_PAY) && wh_mask);

    assign pay_done  = (st_q == ST_PAY) && field_done && (rem_q == '0);
    assign want_byte = (st_q == ST_WAIT) ||
                       ((st_q == ST_LEN) && field_done && (len_q != '0)) ||
                       ((st_q == ST_PAY) && field_done && (rem_q != '0));

    assign s_byte_ready = want_byte;
    assign s_len_ready  = (st_q == ST_IDLE) || ((st_q == ST_CRC) && field_done);
    assign byte_take    = s_byte_valid && s_byte_ready;
    assign len_take     = s_len_valid && s_len_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (len_take) st_d = ST_SYNC;
            ST_SYNC: if (field_done) st_d = ST_LEN;
            ST_LEN: begin
                if (field_done) begin
                    if (len_q == '0)    st_d = ST_CRC;
                    else if (byte_take) st_d = ST_PAY;
                    else                st_d = ST_WAIT;
                end
            end
            ST_WAIT: if (byte_take) st_d = ST_PAY;
            ST_PAY: begin
                if (field_done) begin
                    if (rem_q == '0)    st_d = ST_CRC;
                    else if (byte_take) st_d = ST_PAY;
                    else                st_d = ST_WAIT;
                end
            end
            ST_CRC: begin
                if (field_done) st_d = len_take ? ST_SYNC : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sh_load = 1'b1;
        sh_data = '{word: '0, nbits_m1: '0};
        if (len_take) begin
            sh_data = '{word: SYNC_WORD, nbits_m1: CNT_W'(SYNC_W - 1)};
        end else if ((st_q == ST_SYNC) && field_done) begin
            sh_data = '{word: {len_q, {LEN_PAD{1'b0}}}, nbits_m1: CNT_W'(LEN_W - 1)};
        end else if (byte_take) begin
            sh_data = '{word: {s_byte, {BYTE_PAD{1'b0}}}, nbits_m1: CNT_W'(BYTE_W - 1)};
        end else if (((st_q == ST_LEN) && field_done && (len_q == '0)) || pay_done) begin
            sh_data = '{word: {crc_val, {CRC_PAD{1'b0}}}, nbits_m1: CNT_W'(CRC_W - 1)};
        end else begin
            sh_load = 1'b0;
        end
    end

    assign sh_shift = bit_fire && !sh_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            len_q <= '0;
            rem_q <= '0;
        end else begin
            st_q <= st_d;
            if (len_take) begin
                len_q <= s_len;
                rem_q <= s_len;
            end else if (byte_take) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    fb_field_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (sh_load),
        .load_data_i (sh_data),
        .shift_i     (sh_shift),
        .bit_o       (sh_bit),
        .last_o      (sh_last)
    );

    fb_whitener u_whiten (
        .clk    (clk),
        .rst    (rst),
        .seed_i (len_take),
        .step_i ((st_q == ST_PAY) && bit_fire),
        .mask_o (wh_mask)
    );

    fb_crc16 u_crc (
        .clk    (clk),
        .rst    (rst),
        .init_i (len_take),
        .upd_i  (byte_take),
        .byte_i (s_byte),
        .crc_o  (crc_val)
    );

    // R1: the alignment word is on the line right after a length is taken
    p_sync_follows_len_r1: assert property (@(posedge clk) disable iff (rst)
        (s_len_valid && s_len_ready) |=> m_bit_valid);

    // R7: a stalled bit stays valid and unchanged
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (m_bit_valid && !m_bit_ready) |=> (m_bit_valid && $stable(m_bit)));

    // R8: a taken byte is on the line in the following cycle
    p_byte_to_line_r8: assert property (@(posedge clk) disable iff (rst)
        (s_byte_valid && s_byte_ready) |=> m_bit_valid);

    // R11: length and byte channels are never open together
    p_ready_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(s_len_ready && s_byte_ready));

endmodule

// File: tb/fb_frame_builder_tb.sv
`timescale 1ns/1ps
module fb_frame_builder_tb;

    logic clk = 1'b0;
    logic rst;
    logic s_len_valid, s_len_ready;
    logic [15:0] s_len;
    logic s_byte_valid, s_byte_ready;
    logic [7:0] s_byte;
    logic m_bit_valid, m_bit_ready, m_bit;

    always #2.5 clk = ~clk;

    fb_frame_builder u_dut (
        .clk          (clk),
        .rst          (rst),
        .s_len_valid  (s_len_valid),
        .s_len_ready  (s_len_ready),
        .s_len        (s_len),
        .s_byte_valid (s_byte_valid),
        .s_byte_ready (s_byte_ready),
        .s_byte       (s_byte),
        .m_bit_valid  (m_bit_valid),
        .m_bit_ready  (m_bit_ready),
        .m_bit        (m_bit)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic  exp_b[$];
    string exp_t[$];
    int    lens[$];
    logic [7:0] bytes_all[$];
    int li = 0, bd = 0, be = 0;
    int frame_in_run = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ d[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic expect_frame(input int len);
        logic [31:0] sw = 32'hA5F0_3C96;
        logic [15:0] lv = 16'(len);
        logic [6:0]  s  = 7'h7F;
        logic [15:0] c  = 16'hFFFF;
        for (int i = 31; i >= 0; i--) begin exp_b.push_back(sw[i]); exp_t.push_back("R1"); end
        for (int i = 15; i >= 0; i--) begin exp_b.push_back(lv[i]); exp_t.push_back("R2"); end
        for (int k = 0; k < len; k++) begin
            logic [7:0] b = bytes_all[be];
            be++;
            c = model_crc(c, b);
            for (int i = 7; i >= 0; i--) begin
                exp_b.push_back(b[i] ^ s[6]);
                exp_t.push_back(frame_in_run == 0 ? "R3" : "R4");
                s = {s[5:0], s[6] ^ s[3]};
            end
        end
        for (int i = 15; i >= 0; i--) begin
            exp_b.push_back(c[i]);
            exp_t.push_back(len == 0 ? "R6" : "R5");
        end
        frame_in_run++;
    endtask

    task automatic add_frame(input int len, input int kind);
        lens.push_back(len);
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            case (kind)
                0: v = 8'h00;
                1: v = 8'hFF;
                2: v = 8'(i + 1);
                default: v = 8'(i * 37 + 91);
            endcase
            bytes_all.push_back(v);
        end
    endtask

    task automatic run(input int rmod, input int gmod, input bit gap_chk);
        int cyc = 0;
        int gap = 0;
        bit hold_pend = 0;
        logic hold_bit = 0;
        frame_in_run = 0;
        forever begin
            int pre;
            bit fire;
            @(negedge clk);
            s_len_valid  = (li < lens.size());
            s_len        = (li < lens.size()) ? 16'(lens[li]) : 16'h0;
            s_byte_valid = (bd < bytes_all.size()) && (gmod == 0 || (cyc % gmod) != 0);
            s_byte       = (bd < bytes_all.size()) ? bytes_all[bd] : 8'h00;
            m_bit_ready  = (rmod == 0) || ((cyc % rmod) != 0);
            #1;
            if (hold_pend)
                chk(m_bit_valid && (m_bit == hold_bit), "R7", "stalled bit changed",
                    {m_bit_valid, m_bit}, {1'b1, hold_bit});
            pre = exp_b.size();
            if (!m_bit_valid && pre > 0) begin
                gap++;
                chk(s_byte_ready, "R8", "valid low without byte wait", s_byte_ready, 1);
            end
            fire = m_bit_valid && m_bit_ready;
            if (fire) begin
                if (pre == 0) begin
                    chk(0, "R11", "bit outside any frame", 1, 0);
                end else begin
                    logic  e = exp_b.pop_front();
                    string t = exp_t.pop_front();
                    chk(m_bit === e, t, "line bit", m_bit, e);
                end
            end
            if (s_len_valid && s_len_ready) begin
                chk((pre == 0) || (pre == 1 && fire), "R11", "length taken mid-frame", pre, 0);
                expect_frame(lens[li]);
                li++;
            end
            if (s_byte_valid && s_byte_ready) bd++;
            hold_pend = m_bit_valid && !m_bit_ready;
            hold_bit  = m_bit;
            cyc++;
            if (li == lens.size() && exp_b.size() == 0 && bd == bytes_all.size()) break;
            if (cyc > 50000) begin
                chk(0, "R9", "run did not drain", exp_b.size(), 0);
                break;
            end
        end
        if (gap_chk) chk(gap == 0, "R9", "idle cycles in continuous run", gap, 0);
        @(negedge clk);
        s_len_valid  = 0;
        s_byte_valid = 0;
        #1;
        chk(!m_bit_valid && s_len_ready, "R10", "not idle after run",
            {m_bit_valid, s_len_ready}, 2'b01);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        rst = 1; s_len_valid = 0; s_len = 0; s_byte_valid = 0; s_byte = 0; m_bit_ready = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(!m_bit_valid, "R10", "valid in reset", m_bit_valid, 0);
        chk(s_len_ready,  "R10", "len ready in reset", s_len_ready, 1);
        @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        #1;
        chk(!m_bit_valid && !s_byte_ready && s_len_ready, "R10", "idle after reset",
            {m_bit_valid, s_byte_ready, s_len_ready}, 3'b001);

        // R5 convention: standard check string
        c = 16'hFFFF;
        for (int i = 0; i < 9; i++) c = model_crc(c, 8'(8'h31 + i));
        chk(c == 16'h29B1, "R5", "check string remainder", c, 16'h29B1);
        lens.push_back(9);
        for (int i = 0; i < 9; i++) bytes_all.push_back(8'(8'h31 + i));
        run(0, 0, 1);

        // R6: empty frame alone
        add_frame(0, 0);
        run(0, 0, 1);

        // R3 R4 R9: sweep of lengths and patterns, back to back
        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 10; n++) add_frame(n, k);
        add_frame(5, 0);
        add_frame(5, 0);
        run(0, 0, 1);

        // R7 R8 R11: same sweep under stalls and byte gaps
        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 10; n++) add_frame(n, k);
        run(3, 4, 0);

        add_frame(40, 3);
        add_frame(1, 1);
        add_frame(0, 0);
        run(2, 2, 0);

        add_frame(12, 2);
        add_frame(3, 0);
        run(5, 3, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule